// File: doc/BRIEF.md
# Link Error Monitor with Threshold

The block watches the receive side of a serial link. Each clock it may see a strobe for a decoding (8b10b) error, a strobe for a line-code error, and strobes for loss of lock and loss of recovered clock. It keeps saturating counts of these, which are shown through two readout ports. One of them carries a data-error count: either the errors of the current run or the errors counted in the last completed time window. The other carries an event count: either the link-event counter or the current-run data-error count.

The current-run data-error count is compared with a programmable threshold. The threshold is written one byte half at a time and resets to 0x0010. When the count goes strictly above the threshold, the block leaves its normal state. It then holds its data output at zero, drops its output valid and raises a status flag. It stays in that state until software clears the counts or resets the channel. A control input can disable this exit.

The control fields are presented as plain input pins. They are expected to be driven from the register stage of an enclosing block.

Top module: `link_err_mon`

## Requirements
- R1: After reset the threshold is 0x0010. A pulse on `thr_wr_lo` loads `thr_byte` into threshold bits [7:0]. A pulse on `thr_wr_hi` loads it into bits [15:8]. The other half is kept.
- R2: If the current-run count is strictly greater than the threshold while the block is normal, `err_exit` is 1 from the next cycle. While `err_exit` is 1, `data_vld_out` is 0 and `data_out` is zero. While it is 0, both follow `data_vld_in` and `data_in` combinationally.
- R3: While `no_exit` is 1, the block never leaves the normal state, whatever the count.
- R4: While `mask_8b10b` is 1, an `err_8b10b` strobe does not raise any count and cannot cause an exit. An `err_code` strobe still counts. A cycle that carries any counted data error adds exactly one.
- R5: `win_sel`=0 shows the current-run count on `err_cnt`. `win_sel`=1 shows the count latched at the last window boundary.
- R6: A pulse on `clr_err` zeroes the current-run count, the running window count and the latched window count from the next cycle. An error in the same cycle is lost.
- R7: The link counter adds one in each cycle that has `loss_lock` or `loss_clk`. `evt_sel`=0 shows it on `evt_cnt`; `evt_sel`=1 shows the current-run data-error count there. `clr_link` zeroes only the link counter.
- R8: When `enable` is 0, no counter changes except through a clear.
- R9: Every counter stops at all-ones instead of wrapping.
- R10: A window timer runs through WIN_LEN cycles. In the window's last cycle, the running window count, including that cycle's error, becomes the latched value, and the running count restarts at zero.
- R11: `chan_rst` zeroes every counter and the window timer and returns the block to normal. It keeps the threshold.
- R12: Once exited, the block stays exited until `clr_err` or `chan_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global count enable |
| mask_8b10b | input | 1 | Ignore decoding-error strobes |
| no_exit | input | 1 | Disable threshold exit |
| win_sel | input | 1 | err_cnt source: 0 run, 1 last window |
| evt_sel | input | 1 | evt_cnt source: 0 link events, 1 run errors |
| clr_err | input | 1 | Clear data-error counts and leave exit state |
| clr_link | input | 1 | Clear link-event counter |
| chan_rst | input | 1 | Channel reset of counts, timer and state |
| thr_wr_lo | input | 1 | Write low threshold half |
| thr_wr_hi | input | 1 | Write high threshold half |
| thr_byte | input | CNT_W/2 | Threshold half value |
| err_8b10b | input | 1 | Decoding-error strobe |
| err_code | input | 1 | Line-code error strobe |
| loss_lock | input | 1 | Loss-of-lock strobe |
| loss_clk | input | 1 | Loss of recovered clock strobe |
| data_in | input | DATA_W | Received data word |
| data_vld_in | input | 1 | Received data valid |
| data_out | output | DATA_W | Forwarded data, zero when exited |
| data_vld_out | output | 1 | Forwarded valid, low when exited |
| err_cnt | output | CNT_W | Selected data-error count |
| evt_cnt | output | CNT_W | Selected event count |
| err_exit | output | 1 | Threshold exit status |

## Verification
Some properties are checked on every cycle:
- The output gating while exited.
- The stickiness of the exit state.
- The effect of `no_exit`.
- The saturation and clear behaviour of each counter.
- The timer wrap at the window boundary.
- The absence of run-count growth while only masked strobes arrive.

Other behaviours only show up in the bench's scenarios, where a behavioural model is compared with the outputs every cycle:
- The exact exit cycle for a given threshold.
- The byte-half threshold writes.
- The window latch values, including the error that falls in the boundary cycle.
- The readout selections.
- What `chan_rst` keeps and what it drops.

// File: rtl/lem_pkg.sv
package lem_pkg;
    typedef enum logic {
        LEM_NORMAL = 1'b0,
        LEM_EXITED = 1'b1
    } lem_state_e;
endpackage

// File: rtl/lem_sat_cnt.sv
module lem_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != MAXV) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !clr) |=> cnt_q == MAXV);

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/lem_win.sv
module lem_win #(
    parameter int W       = 16,
    parameter int WIN_LEN = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] prev_q,
    output logic         tick
);
    localparam int TMR_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(WIN_LEN - 1);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [W-1:0]     run;
        logic [W-1:0]     prev;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [W-1:0] sum;

    assign tick   = (st_q.tmr == LAST);
    assign prev_q = st_q.prev;

    always_comb begin
        st_d = st_q;
        sum  = (inc && st_q.run != MAXV) ? st_q.run + 1'b1 : st_q.run;
        if (restart)   st_d.tmr = '0;
        else if (tick) st_d.tmr = '0;
        else           st_d.tmr = st_q.tmr + 1'b1;
        if (clr) begin
            st_d.run  = '0;
            st_d.prev = '0;
        end else if (tick) begin
            st_d.prev = sum;
            st_d.run  = '0;
        end else begin
            st_d.run  = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.tmr == '0 && st_q.run == '0);

    // R6
    win_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.prev == '0);
endmodule

// File: rtl/lem_thr_fsm.sv
module lem_thr_fsm
    import lem_pkg::*;
#(
    parameter int              W       = 16,
    parameter logic [W-1:0]    THR_RST = 'h10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cnt,
    input  logic           no_exit,
    input  logic           leave,
    input  logic           wr_lo,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wr_byte,
    output logic           exited
);
    localparam int HALF = W / 2;

    typedef struct packed {
        lem_state_e   st;
        logic [W-1:0] thr;
    } fsm_st_t;

    fsm_st_t fs_d, fs_q;

    always_comb begin
        fs_d = fs_q;
        if (wr_lo) fs_d.thr[HALF-1:0] = wr_byte;
        if (wr_hi) fs_d.thr[W-1:HALF] = wr_byte;
        if (leave) begin
            fs_d.st = LEM_NORMAL;
        end else if (fs_q.st == LEM_NORMAL && cnt > fs_q.thr && !no_exit) begin
            fs_d.st = LEM_EXITED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q.st  <= LEM_NORMAL;
            fs_q.thr <= THR_RST;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign exited = (fs_q.st == LEM_EXITED);

    // R3
    no_exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exited && no_exit) |=> !exited);

    // R12
    exit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exited && !leave) |=> exited);
endmodule

// File: rtl/link_err_mon.sv
module link_err_mon #(
    parameter int                DATA_W  = 10,
    parameter int                CNT_W   = 16,
    parameter int                WIN_LEN = 64,
    parameter logic [CNT_W-1:0]  THR_RST = 'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               mask_8b10b,
    input  logic               no_exit,
    input  logic               win_sel,
    input  logic               evt_sel,
    input  logic               clr_err,
    input  logic               clr_link,
    input  logic               chan_rst,
    input  logic               thr_wr_lo,
    input  logic               thr_wr_hi,
    input  logic [CNT_W/2-1:0] thr_byte,
    input  logic               err_8b10b,
    input  logic               err_code,
    input  logic               loss_lock,
    input  logic               loss_clk,
    input  logic [DATA_W-1:0]  data_in,
    input  logic               data_vld_in,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_vld_out,
    output logic [CNT_W-1:0]   err_cnt,
    output logic [CNT_W-1:0]   evt_cnt,
    output logic               err_exit
);
    logic             data_hit, link_hit;
    logic             err_clr, lnk_clr;
    logic [CNT_W-1:0] run_q, link_q, prev_q;
    logic             win_tick;

    assign data_hit = enable && ((err_8b10b && !mask_8b10b) || err_code);
    assign link_hit = enable && (loss_lock || loss_clk);
    assign err_clr  = clr_err  || chan_rst;
    assign lnk_clr  = clr_link || chan_rst;

    lem_sat_cnt #(.W(CNT_W)) u_run (
        .clk(clk), .rst_n(rst_n), .clr(err_clr), .inc(data_hit), .cnt_q(run_q)
    );

    lem_sat_cnt #(.W(CNT_W)) u_link (
        .clk(clk), .rst_n(rst_n), .clr(lnk_clr), .inc(link_hit), .cnt_q(link_q)
    );

    lem_win #(.W(CNT_W), .WIN_LEN(WIN_LEN)) u_win (
        .clk(clk), .rst_n(rst_n), .restart(chan_rst), .clr(err_clr),
        .inc(data_hit), .prev_q(prev_q), .tick(win_tick)
    );

    lem_thr_fsm #(.W(CNT_W), .THR_RST(THR_RST)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cnt(run_q), .no_exit(no_exit),
        .leave(err_clr), .wr_lo(thr_wr_lo), .wr_hi(thr_wr_hi),
        .wr_byte(thr_byte), .exited(err_exit)
    );

    assign err_cnt      = win_sel ? prev_q : run_q;
    assign evt_cnt      = evt_sel ? run_q  : link_q;
    assign data_vld_out = data_vld_in && !err_exit;
    assign data_out     = err_exit ? '0 : data_in;

    // R2
    gate_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_exit |-> (!data_vld_out && data_out == '0));

    // R4
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_8b10b && !err_code && !err_clr) |=> $stable(run_q));

    // R11
    chan_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (!err_exit && run_q == '0 && link_q == '0));

    // R10
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_tick && !chan_rst) |=> !win_tick);
endmodule

// File: tb/tb_link_err_mon.sv
`timescale 1ns/1ps
module tb_link_err_mon;
    localparam int DW = 10;
    localparam int CW = 16;
    localparam int WL = 64;
    localparam int MAXC = 65535;

    logic clk = 0;
    logic rst_n = 0;
    logic enable = 0, mask_8b10b = 0, no_exit = 0, win_sel = 0, evt_sel = 0;
    logic clr_err = 0, clr_link = 0, chan_rst = 0, thr_wr_lo = 0, thr_wr_hi = 0;
    logic [7:0] thr_byte = 0;
    logic err_8b10b = 0, err_code = 0, loss_lock = 0, loss_clk = 0;
    logic [DW-1:0] data_in = 0;
    logic data_vld_in = 0;
    logic [DW-1:0] data_out;
    logic data_vld_out;
    logic [CW-1:0] err_cnt, evt_cnt;
    logic err_exit;

    int nchk = 0, nbad = 0, cyc = 0;

    // behavioural reference state
    int m_run, m_win, m_prev, m_link, m_tmr, m_thr;
    bit m_exit;

    always #5 clk = ~clk;

    link_err_mon #(.DATA_W(DW), .CNT_W(CW), .WIN_LEN(WL)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mask_8b10b(mask_8b10b),
        .no_exit(no_exit), .win_sel(win_sel), .evt_sel(evt_sel),
        .clr_err(clr_err), .clr_link(clr_link), .chan_rst(chan_rst),
        .thr_wr_lo(thr_wr_lo), .thr_wr_hi(thr_wr_hi), .thr_byte(thr_byte),
        .err_8b10b(err_8b10b), .err_code(err_code), .loss_lock(loss_lock),
        .loss_clk(loss_clk), .data_in(data_in), .data_vld_in(data_vld_in),
        .data_out(data_out), .data_vld_out(data_vld_out), .err_cnt(err_cnt),
        .evt_cnt(evt_cnt), .err_exit(err_exit)
    );

    function automatic int sat(int v, bit inc);
        return (inc && v < MAXC) ? v + 1 : v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_win = 0; m_prev = 0; m_link = 0; m_tmr = 0;
            m_thr = 16; m_exit = 0;
        end else begin
            bit dh, lh, clr, tk;
            dh  = enable && ((err_8b10b && !mask_8b10b) || err_code);
            lh  = enable && (loss_lock || loss_clk);
            clr = clr_err || chan_rst;
            if (clr) m_exit = 0;
            else if (!m_exit && m_run > m_thr && !no_exit) m_exit = 1;
            if (thr_wr_lo) m_thr = (m_thr & 'hFF00) | thr_byte;
            if (thr_wr_hi) m_thr = (m_thr & 'h00FF) | (int'(thr_byte) << 8);
            m_run = clr ? 0 : sat(m_run, dh);
            tk = (m_tmr == WL - 1);
            if (clr) begin m_win = 0; m_prev = 0; end
            else if (tk) begin m_prev = sat(m_win, dh); m_win = 0; end
            else m_win = sat(m_win, dh);
            m_tmr = (chan_rst || tk) ? 0 : m_tmr + 1;
            m_link = (clr_link || chan_rst) ? 0 : sat(m_link, lh);
        end
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp();
        int e_err, e_evt;
        e_err = win_sel ? m_prev : m_run;
        e_evt = evt_sel ? m_run : m_link;
        chk(err_cnt == CW'(e_err), "R5 R10 err_cnt", err_cnt, e_err);
        chk(evt_cnt == CW'(e_evt), "R7 evt_cnt", evt_cnt, e_evt);
        chk(err_exit == m_exit, "R12 err_exit", err_exit, m_exit);
        chk(data_vld_out == (data_vld_in && !m_exit), "R2 data_vld_out",
            data_vld_out, data_vld_in && !m_exit);
        chk(data_out == (m_exit ? '0 : data_in), "R2 data_out", data_out,
            m_exit ? 0 : data_in);
    endtask

    // advance n cycles, comparing at each falling edge
    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp();
            data_in     = DW'(cyc * 7);
            data_vld_in = cyc[0];
        end
    endtask

    task automatic pulse_clr();
        clr_err = 1; run(1); clr_err = 0;
    endtask

    initial begin : watchdog
        #1_800_000;
        nchk++; nbad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 R11 reset state
        chk(err_cnt == 0 && evt_cnt == 0, "R11 reset counts", err_cnt, 0);
        chk(err_exit == 0, "R1 reset state normal", err_exit, 0);

        // R8 disabled: nothing counts
        err_code = 1; loss_lock = 1; run(5);
        err_code = 0; loss_lock = 0; run(1);
        chk(err_cnt == 0, "R8 disabled run count", err_cnt, 0);

        // R4 masking and single-add rule
        enable = 1; mask_8b10b = 1; err_8b10b = 1; run(4);
        err_code = 1; run(3);
        err_8b10b = 0; err_code = 0; run(1);
        chk(err_cnt == 3, "R4 masked count", err_cnt, 3);
        mask_8b10b = 0; err_8b10b = 1; run(2); err_8b10b = 0; run(1);

        // R7 link events and selection
        loss_clk = 1; run(3); loss_clk = 0; loss_lock = 1; run(2); loss_lock = 0;
        run(1);
        chk(evt_cnt == 5, "R7 link count", evt_cnt, 5);
        evt_sel = 1; run(2); evt_sel = 0;
        clr_link = 1; run(1); clr_link = 0; run(2);
        chk(evt_cnt == 0, "R7 clr_link", evt_cnt, 0);

        // R10 R5 windows, boundary-cycle errors
        pulse_clr();
        win_sel = 1;
        for (int k = 0; k < 300; k++) begin
            err_code = (k % 3 == 0);
            run(1);
        end
        err_code = 0; run(70);
        win_sel = 0; run(2);

        // R6 clear with simultaneous error
        err_code = 1; clr_err = 1; run(1); clr_err = 0; err_code = 0; run(1);
        chk(err_cnt == 0, "R6 clear wins", err_cnt, 0);

        // R2 default threshold 16: 17 errors exit
        err_code = 1; run(17); err_code = 0; run(2);
        chk(err_exit == 1, "R1 R2 exit after 17", err_exit, 1);
        data_vld_in = 1; run(20);
        chk(err_exit == 1, "R12 still exited", err_exit, 1);
        pulse_clr(); run(2);
        chk(err_exit == 0, "R6 clear leaves exit", err_exit, 0);

        // R1 threshold write 0x0003, R3 no_exit
        thr_byte = 8'h03; thr_wr_lo = 1; run(1); thr_wr_lo = 0;
        thr_byte = 8'h00; thr_wr_hi = 1; run(1); thr_wr_hi = 0;
        no_exit = 1; err_code = 1; run(10); err_code = 0; run(3);
        chk(err_exit == 0, "R3 no exit", err_exit, 0);
        no_exit = 0; run(2);
        chk(err_exit == 1, "R1 written threshold", err_exit, 1);
        loss_lock = 1; run(3); loss_lock = 0;
        chan_rst = 1; run(1); chan_rst = 0; run(2);
        chk(err_exit == 0 && evt_cnt == 0, "R11 chan_rst", err_exit, 0);
        err_code = 1; run(4); err_code = 0; run(2);
        chk(err_exit == 1, "R11 threshold kept", err_exit, 1);

        // R9 saturation
        pulse_clr(); no_exit = 1; err_code = 1; loss_clk = 1;
        run(MAXC + 10);
        err_code = 0; loss_clk = 0; run(2);
        chk(err_cnt == 16'hFFFF, "R9 run saturates", err_cnt, 16'hFFFF);
        chk(evt_cnt == 16'hFFFF, "R9 link saturates", evt_cnt, 16'hFFFF);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule